// File: doc/BRIEF.md
# Programmable SCL Clock Divider

This block times the SCL clock of an I2C bus master from the peripheral clock. A split select value sets the division ratio. The low five bits come from the clock control byte and the upper six bits come from the extension byte. Together they form an 11-bit field V, and the count is N = V + 1. A mode bit picks the waveform shape. In standard mode the low and high halves are equal, which gives about 2·N+2 peripheral clocks per bit and suits 100 kHz. In fast mode the high half is shortened to about half the low half, which gives about 1.5·N+2 clocks per bit and suits 400 kHz.

Each bit has two phases. The block drives SCL low for a counted interval and then releases the line. It waits until SCL reads back high before it counts the high interval, so a slave can stretch the clock by holding the line low. At the end of the high interval it pulses a bit tick and starts the next bit. A spacing value, scaled from the peripheral clock frequency, places a single timing strobe inside the high phase; the controller uses it to position start and stop conditions. The divider samples a new configuration only at a bit boundary. Clearing the enable bit stops the divider and releases SCL.

Top module: `scl_clk_div`

## Requirements
- R1: In standard mode (ctl_reg bit 6 = 0) with N = {ext_reg[5:0], ctl_reg[4:0]} + 1, each bit drives scl_low_req high for N+1 cycles and then keeps it low for N+1 cycles, when SCL is not stretched. The bit period is therefore 2·N+2.
- R2: In fast mode (ctl_reg bit 6 = 1), each bit drives scl_low_req high for N+1 cycles and then keeps it low for floor(N/2)+1 cycles, when SCL is not stretched. This also holds at N = 1, where the period is 3 cycles.
- R3: ctl_reg bit 5 is the enable. If it is 0 at a clock edge, then from that edge onward scl_low_req, bit_tick and spc_strobe are all 0. If it is 1 while the divider is stopped, the low phase of a new bit begins at the next edge and lasts N+1 cycles.
- R4: After the divider releases SCL, the high-phase count starts only in the first cycle that scl_in reads 1. Each cycle that a slave holds scl_in low lengthens the high phase by one cycle, and bit_tick and spc_strobe stay 0 during that time.
- R5: bit_tick is a one-cycle pulse in the last cycle of the high phase. It never coincides with scl_low_req, and the cycle after it is the first cycle of a new low phase.
- R6: A change to ctl_reg bits 4:0 or 6, or to ext_reg, during a bit does not alter that bit. The change takes effect from the bit that follows the next bit_tick.
- R7: Number the cycles of the high phase from 0, starting at the first cycle that scl_in reads 1. spc_strobe pulses once, in the cycle whose number equals spc_cnt. If spc_cnt is at least the length of the unstretched high phase, it does not pulse.
- R8: While rst is high at a clock edge, scl_low_req, bit_tick and spc_strobe are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_reg | input | 7 | Clock control: [4:0] low select bits, [5] enable, [6] fast mode |
| ext_reg | input | 6 | Clock extension: bits 10:5 of the select value |
| spc_cnt | input | 4 | Setup/hold spacing count in cycles |
| scl_in | input | 1 | Sampled SCL line level |
| scl_low_req | output | 1 | Request to drive SCL low |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit |
| spc_strobe | output | 1 | One-cycle start/stop timing strobe inside the high phase |

## Verification
A wrong phase counter or a wrong count latch changes the length of the very next low or high run on scl_low_req, measured between consecutive bit_tick pulses. It is therefore visible within one bit period, at most a few thousand cycles at the largest select value. A stuck wait state or a skipped stretch check shows up in the next bit: either a tick goes missing or the high phase ends early while scl_in is held low. A configuration that is latched at the wrong moment changes the length of the bit in which the registers were rewritten, rather than the length of the bit after it.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    parameter int unsigned CS_W  = 5;
    parameter int unsigned EXT_W = 6;
    parameter int unsigned SPC_W = 4;

    localparam int unsigned SEL_W = CS_W + EXT_W;
    localparam int unsigned CNT_W = SEL_W + 1;

    localparam int unsigned CTL_W    = CS_W + 2;
    localparam int unsigned CTL_EN   = CS_W;
    localparam int unsigned CTL_FAST = CS_W + 1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_WAIT,
        PH_HIGH
    } phase_t;

    typedef struct packed {
        logic [CNT_W-1:0] lo_len;
        logic [CNT_W-1:0] hi_len;
        logic [SPC_W-1:0] spc;
    } bit_cfg_t;

    function automatic logic [CNT_W-1:0] high_len(input logic [CNT_W-1:0] n,
                                                  input logic fast);
        return fast ? (n >> 1) : n;
    endfunction

endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
    import clkdiv_pkg::*;
(
    input  logic [CS_W-1:0]  sel_lo,
    input  logic [EXT_W-1:0] sel_hi,
    input  logic             fast,
    input  logic [SPC_W-1:0] spc,
    output bit_cfg_t         cfg
);

    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] n_cnt;

    always_comb begin
        sel        = {sel_hi, sel_lo};
        n_cnt      = CNT_W'(sel) + CNT_W'(1);
        cfg.lo_len = n_cnt + CNT_W'(1);
        cfg.hi_len = high_len(n_cnt, fast);
        cfg.spc    = spc;
    end

endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
    import clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     scl_in,
    input  bit_cfg_t nxt_cfg,
    output logic     scl_low_req,
    output logic     bit_tick,
    output logic     spc_strobe
);

    phase_t           ph;
    logic [CNT_W-1:0] cnt;
    bit_cfg_t         cur;
    logic             hi_empty;
    logic             lo_last;
    logic             hi_last;

    always_comb begin
        hi_empty    = (cur.hi_len == '0);
        lo_last     = (cnt == cur.lo_len - CNT_W'(1));
        hi_last     = (cnt == cur.hi_len - CNT_W'(1));
        scl_low_req = (ph == PH_LOW);
        bit_tick    = ((ph == PH_WAIT) && scl_in && hi_empty) ||
                      ((ph == PH_HIGH) && hi_last);
        spc_strobe  = ((ph == PH_WAIT) && scl_in && (cur.spc == '0)) ||
                      ((ph == PH_HIGH) && ((cnt + CNT_W'(1)) == CNT_W'(cur.spc)));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph  <= PH_IDLE;
            cnt <= '0;
            if (rst) cur <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    ph  <= PH_LOW;
                    cnt <= '0;
                    cur <= nxt_cfg;
                end
                PH_LOW: begin
                    if (lo_last) begin
                        ph  <= PH_WAIT;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_WAIT: begin
                    if (scl_in) begin
                        cnt <= '0;
                        if (hi_empty) begin
                            ph  <= PH_LOW;
                            cur <= nxt_cfg;
                        end else begin
                            ph <= PH_HIGH;
                        end
                    end
                end
                PH_HIGH: begin
                    if (hi_last) begin
                        ph  <= PH_LOW;
                        cnt <= '0;
                        cur <= nxt_cfg;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R3
    en_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!scl_low_req && !bit_tick && !spc_strobe));

    // R4
    stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && ph == PH_WAIT && !scl_in) |=> !scl_low_req);

    // R5
    tick_then_low_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && en) |=> scl_low_req);

    // R5
    tick_released_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> !scl_low_req);

    // R1
    low_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_LOW) |-> (cnt < cur.lo_len));

    // R6
    cfg_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (en && ph == PH_LOW && cnt != '0) |-> $stable(cur));

endmodule

// File: rtl/scl_clk_div.sv
module scl_clk_div
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CTL_W-1:0] ctl_reg,
    input  logic [EXT_W-1:0] ext_reg,
    input  logic [SPC_W-1:0] spc_cnt,
    input  logic             scl_in,
    output logic             scl_low_req,
    output logic             bit_tick,
    output logic             spc_strobe
);

    bit_cfg_t nxt_cfg;

    clkdiv_cfg u_cfg (
        .sel_lo (ctl_reg[CS_W-1:0]),
        .sel_hi (ext_reg),
        .fast   (ctl_reg[CTL_FAST]),
        .spc    (spc_cnt),
        .cfg    (nxt_cfg)
    );

    clkdiv_phase u_phase (
        .clk         (clk),
        .rst         (rst),
        .en          (ctl_reg[CTL_EN]),
        .scl_in      (scl_in),
        .nxt_cfg     (nxt_cfg),
        .scl_low_req (scl_low_req),
        .bit_tick    (bit_tick),
        .spc_strobe  (spc_strobe)
    );

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!scl_low_req && !bit_tick && !spc_strobe));

endmodule

// File: tb/scl_clk_div_tb.sv
module scl_clk_div_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] ctl_reg = '0;
    logic [5:0] ext_reg = '0;
    logic [3:0] spc_cnt = '0;
    logic       scl_in;
    logic       scl_low_req;
    logic       bit_tick;
    logic       spc_strobe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int stretch_len = 0;
    int stretch_cnt = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (scl_low_req) stretch_cnt <= stretch_len;
        else if (stretch_cnt > 0) stretch_cnt <= stretch_cnt - 1;
    end

    assign scl_in = !scl_low_req && (stretch_cnt == 0);

    scl_clk_div u_dut (
        .clk         (clk),
        .rst         (rst),
        .ctl_reg     (ctl_reg),
        .ext_reg     (ext_reg),
        .spc_cnt     (spc_cnt),
        .scl_in      (scl_in),
        .scl_low_req (scl_low_req),
        .bit_tick    (bit_tick),
        .spc_strobe  (spc_strobe)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_lo(input int n);
        return n + 1;
    endfunction

    function automatic int hi_core(input int n, input bit fast);
        return fast ? n / 2 : n;
    endfunction

    function automatic int exp_hi(input int n, input bit fast, input int k);
        return k + 1 + hi_core(n, fast);
    endfunction

    function automatic int exp_sp(input int n, input bit fast, input int k, input int s);
        return (s <= hi_core(n, fast)) ? k + s : -1;
    endfunction

    task automatic set_cfg(input int cs, input int ext, input bit fast, input int s);
        ctl_reg = {fast, 1'b1, 5'(cs)};
        ext_reg = 6'(ext);
        spc_cnt = 4'(s);
    endtask

    // counts from the current negedge: low run, then high run through the tick
    task automatic measure_cur(output int lo, output int hi, output int sp);
        lo = 0;
        hi = 0;
        sp = -1;
        while (scl_low_req) begin
            lo++;
            @(negedge clk);
        end
        forever begin
            if (spc_strobe) sp = hi;
            hi++;
            if (bit_tick) break;
            @(negedge clk);
        end
    endtask

    task automatic measure_next(output int lo, output int hi, output int sp);
        do @(negedge clk); while (!bit_tick);
        @(negedge clk);
        measure_cur(lo, hi, sp);
    endtask

    task automatic run_case(input string tag, input int cs, input int ext,
                            input bit fast, input int s, input int k);
        int lo, hi, sp, n;
        n = ext * 32 + cs + 1;
        stretch_len = k;
        set_cfg(cs, ext, fast, s);
        measure_next(lo, hi, sp);
        check({tag, " low"}, lo, exp_lo(n));
        check({tag, " high"}, hi, exp_hi(n, fast, k));
        check({tag, " spacing"}, sp, exp_sp(n, fast, k, s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lo, hi, sp;
        void'($urandom(32'd20240611));

        // R8: outputs quiet during reset
        repeat (3) @(negedge clk);
        check("R8 reset low_req", int'(scl_low_req), 0);
        check("R8 reset tick", int'(bit_tick), 0);
        ctl_reg = 7'b0100011;
        @(negedge clk);
        check("R8 reset overrides enable", int'(scl_low_req), 0);
        rst = 1'b0;

        // R3: start from enable, low phase right away
        @(negedge clk);
        check("R3 enable start", int'(scl_low_req), 1);
        measure_cur(lo, hi, sp);
        check("R3 first low", lo, exp_lo(4));

        // R1 standard, no stretch
        run_case("R1 std", 9, 0, 1'b0, 3, 0);
        run_case("R1 std ext", 7, 2, 1'b0, 15, 0);
        // R2 fast, including N=1
        run_case("R2 fast", 12, 0, 1'b1, 2, 0);
        run_case("R2 fast N1", 0, 0, 1'b1, 0, 0);
        run_case("R1 std N1", 0, 0, 1'b0, 1, 0);
        // R7 spacing beyond the high phase gives no strobe
        run_case("R7 spc late", 3, 0, 1'b1, 9, 0);
        run_case("R7 spc edge", 3, 0, 1'b0, 4, 0);
        // R4 stretching
        run_case("R4 stretch std", 5, 0, 1'b0, 2, 4);
        run_case("R4 stretch fast N1", 0, 0, 1'b1, 0, 3);
        stretch_len = 0;

        // R1 widest count, extension fully set
        run_case("R1 max", 31, 63, 1'b0, 5, 0);

        // R6: change mid-bit, old values hold until the next boundary
        set_cfg(6, 0, 1'b0, 1);
        do @(negedge clk); while (!bit_tick);
        do @(negedge clk); while (!bit_tick);
        @(negedge clk);
        set_cfg(20, 1, 1'b1, 1);
        measure_cur(lo, hi, sp);
        check("R6 old low", lo, exp_lo(7));
        check("R6 old high", hi, exp_hi(7, 1'b0, 0));
        @(negedge clk);
        measure_cur(lo, hi, sp);
        check("R6 new low", lo, exp_lo(53));
        check("R6 new high", hi, exp_hi(53, 1'b1, 0));

        // R5: cycle after tick is low
        do @(negedge clk); while (!bit_tick);
        check("R5 tick released", int'(scl_low_req), 0);
        @(negedge clk);
        check("R5 low after tick", int'(scl_low_req), 1);
        check("R5 tick one cycle", int'(bit_tick), 0);

        // R3: disable mid-bit
        repeat (3) @(negedge clk);
        ctl_reg[5] = 1'b0;
        @(negedge clk);
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 120; i++) begin
                if (scl_low_req || bit_tick || spc_strobe) seen++;
                @(negedge clk);
            end
            check("R3 disabled quiet", seen, 0);
        end
        set_cfg(10, 0, 1'b0, 0);
        @(negedge clk);
        measure_cur(lo, hi, sp);
        check("R3 restart low", lo, exp_lo(11));
        check("R3 restart high", hi, exp_hi(11, 1'b0, 0));

        // random mix over R1, R2, R4, R7
        for (int it = 0; it < 24; it++) begin
            int cs, ext, s, k;
            bit fast;
            cs   = int'($urandom % 32);
            ext  = int'($urandom % 4);
            fast = 1'($urandom % 2);
            s    = int'($urandom % 16);
            k    = int'($urandom % 6);
            run_case(fast ? "R2 R4 R7 rand" : "R1 R4 R7 rand", cs, ext, fast, s, k);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule